// File: doc/BRIEF.md
# Packet-Locked Elastic Router Output Port

This block is one output port of a router switch in a network whose flow control lives entirely in elastic storage. The router holds no per-input queues, no virtual channels and no credit counters. Several input ports each present one flit at a time with a valid/ready pair. The block computes a dimension-ordered route for every presented head flit, and arbitrates among the heads that route to this port. It then hands the port to the winning packet until that packet's tail flit has gone through. The admitted flits fill a small elastic output buffer that drives the outgoing channel.

An input that is not granted sees ready low and keeps its flit in place, so back-pressure travels upstream through the elastic channel stages. Each instance carries a single traffic class. Request and reply traffic are isolated by building separate physical networks, not by sharing this port.

Top module: `ebr_output_port`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is low, and no `in_ready` bit is high while no input is valid.
- R2: A flit's type is in bits [FLIT_W-1:FLIT_W-2]: type bit 0 marks a head and type bit 1 marks a tail (01 head, 00 body, 10 tail, 11 single-flit packet). Destination x is in bits [COORD_W-1:0] and destination y is in bits [2*COORD_W-1:COORD_W]. A head requests this port only when its route names the port. With the default north port, that means destination x equals local x and destination y is greater than local y.
- R3: Routing resolves x before y. Any head whose destination x differs from local x goes east (larger x) or west (smaller x) and never to the north or south port, whatever its y.
- R4: A head whose destination equals the local coordinates is routed to the local (eject) port and does not request any of the four mesh directions.
- R5: When the port is free, the grant among requesting heads goes to the first requester at or after a rotating pointer. After reset the pointer is input 0. Each packet start moves the pointer to one past the winner.
- R6: Once a head that is not also a tail is admitted, only that input can receive `in_ready` until its tail flit is admitted. Body and tail flits of the owner pass regardless of their coordinate bits.
- R7: At most one `in_ready` bit is high in any cycle, and only for an input whose `in_valid` is high. `in_ready` answers in the same cycle as `in_valid`.
- R8: The output buffer holds DEPTH (default 3) flits. When it is full, no input receives `in_ready`, even in a cycle where the output is being drained.
- R9: An admitted flit appears on `out_flit` with `out_valid` high in the cycle after the edge that admitted it, if the buffer was empty. Flits leave in admission order.
- R10: While `out_valid` is high and `out_ready` is low, `out_flit` and `out_valid` hold their values.
- R11: While the port is free, a body or tail flit is ignored. It receives no `in_ready` and nothing reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| here_x | input | COORD_W | X coordinate of this router |
| here_y | input | COORD_W | Y coordinate of this router |
| in_flit | input | N_IN*FLIT_W | Flits of all inputs, input i at bits [i*FLIT_W +: FLIT_W] |
| in_valid | input | N_IN | Per-input flit present |
| in_ready | output | N_IN | Per-input flit taken at this edge |
| out_flit | output | FLIT_W | Flit at the head of the output buffer |
| out_valid | output | 1 | Output buffer not empty |
| out_ready | input | 1 | Downstream channel stage accepts the flit |

## Verification
`in_ready` is a same-cycle function of the presented flits, the lock and the buffer fill. The bench therefore drives inputs on the falling edge and reads `in_ready` one nanosecond later, before the rising edge that would take the flit. An admitted flit reaches `out_flit` through one register, so the bench checks it at the next falling edge, against the flit its own arbitration model predicted for the previous edge. In the fill test, a full buffer blocks admission in the same cycle. A pop frees a slot that becomes visible on `in_ready` only in the following cycle, and the bench's expected values step through exactly that sequence.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

   typedef enum logic [2:0] {
      DIR_EAST  = 3'd0,
      DIR_WEST  = 3'd1,
      DIR_NORTH = 3'd2,
      DIR_SOUTH = 3'd3,
      DIR_LOCAL = 3'd4
   } dir_e;

   localparam int TYPE_W = 2;

endpackage

// File: rtl/ebr_route.sv
module ebr_route #(
   parameter int COORD_W = 3
) (
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [COORD_W-1:0] here_x,
   input  logic [COORD_W-1:0] here_y,
   output ebr_pkg::dir_e      dir
);
   // x offset resolved first, then y, then eject
   always_comb begin
      if (dst_x > here_x)      dir = ebr_pkg::DIR_EAST;
      else if (dst_x < here_x) dir = ebr_pkg::DIR_WEST;
      else if (dst_y > here_y) dir = ebr_pkg::DIR_NORTH;
      else if (dst_y < here_y) dir = ebr_pkg::DIR_SOUTH;
      else                     dir = ebr_pkg::DIR_LOCAL;
   end
endmodule

// File: rtl/ebr_pkt_arb.sv
module ebr_pkt_arb #(
   parameter int N_IN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] req,
   input  logic [N_IN-1:0] valid,
   input  logic [N_IN-1:0] tail,
   input  logic            space,
   output logic [N_IN-1:0] grant
);
   localparam int IDX_W = $clog2(N_IN);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_IN - 1);

   logic             locked;
   logic [IDX_W-1:0] owner;
   logic [IDX_W-1:0] ptr;
   logic [IDX_W-1:0] win;
   logic             found;
   logic             fire;

   // rotating search starting at ptr
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 0; k < N_IN; k++) begin
         if (!found && req[(int'(ptr) + k) % N_IN]) begin
            found = 1'b1;
            win   = IDX_W'((int'(ptr) + k) % N_IN);
         end
      end
   end

   always_comb begin
      grant = '0;
      if (space) begin
         if (locked) begin
            if (valid[owner]) grant[owner] = 1'b1;
         end else if (found) begin
            grant[win] = 1'b1;
         end
      end
   end

   assign fire = |grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         owner  <= '0;
         ptr    <= '0;
      end else if (fire) begin
         if (!locked) begin
            ptr <= (win == LAST) ? '0 : win + 1'b1;
            if (!tail[win]) begin
               locked <= 1'b1;
               owner  <= win;
            end
         end else if (tail[owner]) begin
            locked <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ebr_outbuf.sv
module ebr_outbuf #(
   parameter int WIDTH = 66,
   parameter int DEPTH = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   output logic                       space,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic                       dvalid,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             do_push;
   logic             do_pop;

   assign space   = fill < CNT_W'(DEPTH);
   assign dvalid  = fill != '0;
   assign dout    = slot[rd_ptr];
   assign do_push = push && space;
   assign do_pop  = pop && dvalid;

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PTR_W'(s)) slot[s] <= din;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         fill <= fill + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end
endmodule

// File: rtl/ebr_output_port.sv
module ebr_output_port #(
   parameter int            N_IN     = 4,
   parameter int            DATA_W   = 64,
   parameter int            COORD_W  = 3,
   parameter int            DEPTH    = 3,
   parameter ebr_pkg::dir_e OUT_PORT = ebr_pkg::DIR_NORTH,
   localparam int           FLIT_W   = DATA_W + ebr_pkg::TYPE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [COORD_W-1:0]       here_x,
   input  logic [COORD_W-1:0]       here_y,
   input  logic [N_IN*FLIT_W-1:0]   in_flit,
   input  logic [N_IN-1:0]          in_valid,
   output logic [N_IN-1:0]          in_ready,
   output logic [FLIT_W-1:0]        out_flit,
   output logic                     out_valid,
   input  logic                     out_ready
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (N_IN >= 2) else $error("N_IN must be at least 2");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (DATA_W >= 2 * COORD_W) else $error("DATA_W too narrow for coordinates");
   end

   logic [FLIT_W-1:0] flit_arr [N_IN];
   logic [N_IN-1:0]   req;
   logic [N_IN-1:0]   tail;
   logic [N_IN-1:0]   grant;
   logic              space;
   logic [FLIT_W-1:0] sel_flit;
   logic [CNT_W-1:0]  fill;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         ebr_pkg::dir_e dir;
         assign flit_arr[i] = in_flit[i*FLIT_W +: FLIT_W];
         ebr_route #(.COORD_W(COORD_W)) u_route (
            .dst_x  (flit_arr[i][COORD_W-1:0]),
            .dst_y  (flit_arr[i][2*COORD_W-1:COORD_W]),
            .here_x (here_x),
            .here_y (here_y),
            .dir    (dir)
         );
         assign req[i]  = in_valid[i] && flit_arr[i][FLIT_W-2] && (dir == OUT_PORT);
         assign tail[i] = flit_arr[i][FLIT_W-1];
      end
   endgenerate

   ebr_pkt_arb #(.N_IN(N_IN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .valid (in_valid),
      .tail  (tail),
      .space (space),
      .grant (grant)
   );

   always_comb begin
      sel_flit = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (grant[i]) sel_flit |= flit_arr[i];
      end
   end

   assign in_ready = grant;

   ebr_outbuf #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_obuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (|grant),
      .din    (sel_flit),
      .space  (space),
      .pop    (out_ready),
      .dout   (out_flit),
      .dvalid (out_valid),
      .fill   (fill)
   );
endmodule

// File: rtl/ebr_output_port_chk.sv
module ebr_output_port_chk #(
   parameter int N_IN   = 4,
   parameter int FLIT_W = 66,
   parameter int DEPTH  = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_IN*FLIT_W-1:0]     in_flit,
   input logic [N_IN-1:0]            in_valid,
   input logic [N_IN-1:0]            in_ready,
   input logic [FLIT_W-1:0]          out_flit,
   input logic                       out_valid,
   input logic                       out_ready,
   input logic [$clog2(DEPTH+1)-1:0] fill
);
   logic            pend;
   logic [N_IN-1:0] own;
   logic [1:0]      acc_t;
   logic            fire;

   always_comb begin
      acc_t = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (in_ready[i] && in_valid[i]) acc_t = in_flit[i*FLIT_W + FLIT_W - 2 +: 2];
      end
   end
   assign fire = |(in_ready & in_valid);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         own  <= '0;
      end else if (fire) begin
         if (!pend && acc_t[0] && !acc_t[1]) begin
            pend <= 1'b1;
            own  <= in_ready;
         end else if (pend && acc_t[1]) begin
            pend <= 1'b0;
         end
      end
   end

   AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(in_ready)); // R7
   AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) (in_ready & ~in_valid) == '0); // R7
   AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n) (pend && |in_ready) |-> in_ready == own); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (fill == ($clog2(DEPTH+1))'(DEPTH)) |-> in_ready == '0); // R8
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_flit))); // R10
   AST_HEAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n) (!pend && fire) |-> acc_t[0]); // R11
endmodule

bind ebr_output_port ebr_output_port_chk #(
   .N_IN   (N_IN),
   .FLIT_W (FLIT_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_flit   (in_flit),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_flit  (out_flit),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .fill      (fill)
);

// File: tb/test_ebr_output_port.sv
`timescale 1ns/1ps
module test_ebr_output_port;
   localparam int N  = 4;
   localparam int DW = 64;
   localparam int CW = 3;
   localparam int FW = DW + 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [CW-1:0]     here_x, here_y;
   logic [N*FW-1:0]   in_flit;
   logic [N-1:0]      in_valid;
   logic [N-1:0]      in_ready;
   logic [FW-1:0]     out_flit;
   logic              out_valid;
   logic              out_ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   ebr_output_port i_ebr_output_port (
      .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
      .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
      .out_flit(out_flit), .out_valid(out_valid), .out_ready(out_ready)
   );

   // bench-side state
   logic [FW-1:0] fl [N];
   logic [FW-1:0] q  [N][8];
   int qn [N];
   int qi [N];
   bit mlock; int mown; int mptr;
   bit hp; logic [FW-1:0] pf;

   function automatic logic [FW-1:0] mk(input logic [1:0] t, input int dx, input int dy, input int tag);
      logic [FW-1:0] f;
      f = '0;
      f[FW-1 -: 2] = t;
      f[2:0]  = 3'(dx);
      f[5:3]  = 3'(dy);
      f[15:8] = 8'(tag);
      return f;
   endfunction

   function automatic bit goes_north(input logic [FW-1:0] f);
      return (f[2:0] == here_x) && (f[5:3] > here_y);
   endfunction

   task automatic chk(input string r, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic drive_inputs();
      for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = fl[i];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = '0; out_ready = 1'b1;
      for (int i = 0; i < N; i++) begin fl[i] = '0; qn[i] = 0; qi[i] = 0; end
      drive_inputs();
      mlock = 0; mown = 0; mptr = 0; hp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 out_valid after reset", FW'(out_valid), FW'(0));
      chk("R1 in_ready idle", FW'(in_ready), FW'(0));
   endtask

   // traffic engine: expected grants from the arbitration rules (R5, R6, R11)
   task automatic run(input string tag, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         logic [N-1:0] eg;
         int w;
         @(negedge clk);
         if (hp) begin
            chk("R9 out_valid after admit", FW'(out_valid), FW'(1));
            chk("R9 out_flit after admit", out_flit, pf);
         end else begin
            chk("R9 out_valid idle", FW'(out_valid), FW'(0));
         end
         for (int i = 0; i < N; i++) begin
            if (qi[i] < qn[i]) begin in_valid[i] = 1'b1; fl[i] = q[i][qi[i]]; end
            else begin in_valid[i] = 1'b0; fl[i] = '0; end
         end
         drive_inputs();
         eg = '0; w = -1;
         if (mlock) begin
            if (in_valid[mown]) w = mown;
         end else begin
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (mptr + k) % N;
               if (w < 0 && in_valid[idx] && fl[idx][FW-2] && goes_north(fl[idx])) w = idx;
            end
         end
         if (w >= 0) eg[w] = 1'b1;
         #1;
         chk(tag, FW'(in_ready), FW'(eg));
         @(posedge clk);
         if (w >= 0) begin
            hp = 1; pf = fl[w]; qi[w]++;
            if (!mlock) begin
               mptr = (w + 1) % N;
               if (!pf[FW-1]) begin mlock = 1; mown = w; end
            end else if (pf[FW-1]) begin
               mlock = 0;
            end
         end else begin
            hp = 0;
         end
      end
      @(negedge clk);
      in_valid = '0;
      if (hp) chk("R9 last flit", out_flit, pf);
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      here_x = 3'd2; here_y = 3'd2;
      in_valid = '0; in_flit = '0; out_ready = 1'b1; rst_n = 1'b0;
      do_reset();

      // R2/R3/R4: route sweep over all destinations for several local positions
      for (int lx = 0; lx < 8; lx += 3) begin
         for (int ly = 0; ly < 8; ly += 3) begin
            for (int d = 0; d < 64; d++) begin
               bit exp;
               string r;
               int dx, dy;
               dx = d % 8; dy = d / 8;
               @(negedge clk);
               here_x = 3'(lx); here_y = 3'(ly);
               fl[0] = mk(2'b11, dx, dy, d);
               in_valid = 4'b0001;
               drive_inputs();
               exp = (dx == lx) && (dy > ly);
               if (dx != lx) r = "R3 x-first route";
               else if (dy == ly) r = "R4 eject not north";
               else r = "R2 north route";
               #1;
               chk(r, FW'(in_ready), FW'({3'b000, exp}));
               @(posedge clk);
               @(negedge clk);
               in_valid = '0;
               chk("R9 one-cycle latency", FW'(out_valid), FW'(exp));
               if (exp) chk("R9 routed flit", out_flit, fl[0]);
            end
         end
      end

      here_x = 3'd2; here_y = 3'd2;

      // R5: all four inputs competing with single-flit packets
      do_reset();
      for (int i = 0; i < N; i++) begin
         qn[i] = 3;
         for (int j = 0; j < 3; j++) q[i][j] = mk(2'b11, 2, 5, i*16 + j);
      end
      run("R5 round-robin all inputs", 14);

      // R5: sparse requesters 1 and 3
      do_reset();
      qn[1] = 3; qn[3] = 3;
      for (int j = 0; j < 3; j++) begin
         q[1][j] = mk(2'b11, 2, 6, 32 + j);
         q[3][j] = mk(2'b11, 2, 7, 48 + j);
      end
      run("R5 round-robin sparse", 8);

      // R6: multi-flit packet holds the port; body/tail carry foreign coordinates
      do_reset();
      qn[0] = 3; q[0][0] = mk(2'b01, 2, 4, 1); q[0][1] = mk(2'b00, 7, 0, 2); q[0][2] = mk(2'b10, 0, 7, 3);
      qn[1] = 1; q[1][0] = mk(2'b11, 2, 3, 4);
      qn[2] = 2; q[2][0] = mk(2'b01, 2, 5, 5); q[2][1] = mk(2'b10, 5, 5, 6);
      run("R6 packet lock", 10);

      // R11: lone body and tail flits while the port is free
      do_reset();
      qn[2] = 1; q[2][0] = mk(2'b00, 2, 5, 7);
      qn[3] = 1; q[3][0] = mk(2'b10, 2, 6, 8);
      run("R11 orphan flit ignored", 5);

      // R8/R10: fill the buffer with the output stalled, then drain in order
      do_reset();
      out_ready = 1'b0;
      for (int j = 0; j < 4; j++) q[0][j] = mk(2'b11, 2, 5, 64 + j);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         fl[0] = q[0][j]; in_valid = 4'b0001; drive_inputs();
         #1;
         chk("R8 slot free", FW'(in_ready), FW'(1));
         if (j > 0) chk("R10 head held", out_flit, q[0][0]);
         @(posedge clk);
      end
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         fl[0] = q[0][3]; drive_inputs();
         #1;
         chk("R8 full blocks input", FW'(in_ready), FW'(0));
         chk("R10 out_valid held", FW'(out_valid), FW'(1));
         chk("R10 out_flit held", out_flit, q[0][0]);
         @(posedge clk);
      end
      @(negedge clk);
      out_ready = 1'b1;
      #1;
      chk("R8 full blocks during pop", FW'(in_ready), FW'(0));
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R9 order second", out_flit, q[0][1]);
      chk("R8 slot reopens", FW'(in_ready), FW'(1));
      @(posedge clk);
      @(negedge clk);
      in_valid = '0;
      chk("R9 order third", out_flit, q[0][2]);
      @(posedge clk);
      @(negedge clk);
      chk("R9 order fourth", out_flit, q[0][3]);
      @(posedge clk);
      @(negedge clk);
      chk("R9 drained", FW'(out_valid), FW'(0));

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule